// File: doc/BRIEF.md
# Auto-reload 8-bit timer with toggle output

This block is an 8-bit up-counting timer that sits on a small synchronous register bus. Software loads a start value, picks one of eight count sources and sets the run bit; the counter then advances once per count strobe. When it passes 0xFF it restarts from a reload value, pulses an interrupt request and a separate baud tick for an attached serial port, and inverts an output level. Each overflow therefore marks the end of one programmable period.

The count source is either the system clock divided by a power of two (1 to 64) or the rising edges of an external input. The divided sources come from one free-running prescaler. The external input is resynchronized before its edges are detected. The output level is a bit of the control register, so software can preset it before starting. Three bits of that register are fixed and read back as 1.

Top module: `reload_timer`

## Requirements
- R1: When a count strobe arrives while the counter holds 0xFF, the counter loads the reload value instead of wrapping to 0, and an overflow is signalled.
- R2: A bus write to address 0 (counter) places the same data in both the counter and the reload register. A write to address 1 changes only the reload register.
- R3: The counter advances only while control bit 3 (run) is 1. With run at 0 its value does not change.
- R4: Control bit 7 drives `timerOut`. A software write sets it, and it inverts on every overflow.
- R5: Control bits 6 to 4 ignore writes and always read as 1.
- R6: After reset the control register reads 0x70, and `timerOut`, `irqPulse` and `baudTick` are 0.
- R7: Control bits 2:0 select the count source. A value k from 0 to 6 counts once every 2^k clocks, so the overflow period is (256 − reload) × 2^k clocks.
- R8: Select value 7 counts once per rising edge of `extCountIn`, after a two-flop synchronizer. A long high level counts only once.
- R9: If a control write and an overflow fall in the same cycle, bit 7 takes the written value and is not inverted.
- R10: `irqPulse` is high for exactly the one cycle after each overflow, and `baudTick` is high in the same cycles.
- R11: Read data is combinational: address 0 returns the counter, 1 the reload register, 2 the control register, and 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe for the addressed register |
| busAddr | input | 2 | Register address (0 counter, 1 reload, 2 control) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for `busAddr` |
| extCountIn | input | 1 | Asynchronous external count input (select 7) |
| timerOut | output | 1 | Output level, control bit 7 |
| irqPulse | output | 1 | One-cycle interrupt request per overflow |
| baudTick | output | 1 | One-cycle tick for a serial port, same cycle as `irqPulse` |

## Verification
The bench uses the default parameters: a 3-bit source select and a two-stage synchronizer. With these, the largest divisor is 64, so each prescaled source can be timed over a full overflow period in a few hundred clocks. Reload values near 0xFF keep the periods short, and one reload of 0x00 covers the full 256-step count. Two synchronizer stages make the external-edge latency short enough that pulses of a few clocks are counted reliably. This lets the bench test counts of single edges and of one long high level.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef struct packed {
    logic cntWr;    // bus writes counter (and reload)
    logic rldWr;    // bus writes reload only
    logic ctlWr;    // bus writes control
    logic countEn;  // one-cycle count strobe
  } tmrStrobes_t;

  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_RLD = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic             wrLevel,
  input  logic             wrRun,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             extCountIn,
  input  logic             wrapEvent,
  output tmrStrobes_t      strobes,
  output logic             timerLevel,
  output logic             runBit,
  output logic [SEL_W-1:0] clkSel
);
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int DIV_SRC = NUM_SRC - 1;
  localparam int PRESC_W = DIV_SRC - 1;

  logic [PRESC_W-1:0]     presc;
  logic [NUM_SRC-1:0]     srcTick;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic                   extRise;

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end

  assign srcTick[0] = 1'b1;
  generate
    for (genvar k = 1; k < DIV_SRC; k++) begin : g_div
      assign srcTick[k] = &presc[k-1:0];
    end
  endgenerate

  // external input: synchronizer and rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extCountIn};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end
  assign extRise = syncQ[SYNC_STAGES-1] & ~extPrev;
  assign srcTick[NUM_SRC-1] = extRise;

  // bus decode and count strobe
  always_comb begin
    strobes.cntWr   = busWe && (busAddr == ADDR_CNT);
    strobes.rldWr   = busWe && (busAddr == ADDR_RLD);
    strobes.ctlWr   = busWe && (busAddr == ADDR_CTL);
    strobes.countEn = runBit && srcTick[clkSel];
  end

  // control register; software write beats hardware toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerLevel <= 1'b0;
      runBit     <= 1'b0;
      clkSel     <= '0;
    end else if (strobes.ctlWr) begin
      timerLevel <= wrLevel;
      runBit     <= wrRun;
      clkSel     <= wrSel;
    end else if (wrapEvent) begin
      timerLevel <= ~timerLevel;
    end
  end

  AST_EXT_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise); // R8
  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ctlWr |=> timerLevel == $past(wrLevel)); // R9
  AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvent && !strobes.ctlWr) |=> timerLevel != $past(timerLevel)); // R4
endmodule

// File: rtl/rtmr_datapath.sv
module rtmr_datapath
  import rtmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] rldQ,
  output logic              wrapEvent,
  output logic              irqPulse,
  output logic              baudTick
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  assign wrapEvent = strobes.countEn && !strobes.cntWr && (cntQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.cntWr)   cntQ <= wrData;
    else if (strobes.countEn) cntQ <= (cntQ == CNT_MAX) ? rldQ : cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rldQ <= '0;
    else if (strobes.cntWr || strobes.rldWr)  rldQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      irqPulse <= wrapEvent;
      baudTick <= wrapEvent;
    end
  end

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> cntQ == $past(rldQ)); // R1
  AST_CNT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntWr |=> (cntQ == rldQ) && (cntQ == $past(wrData))); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEn && !strobes.cntWr) |=> cntQ == $past(cntQ)); // R3
  AST_IRQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> irqPulse && baudTick); // R10
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       extCountIn,
  output logic       timerOut,
  output logic       irqPulse,
  output logic       baudTick
);
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  tmrStrobes_t       strobes;
  logic              wrapEvent;
  logic              runBit;
  logic [SEL_W-1:0]  clkSel;
  logic [DATA_W-1:0] cntQ;
  logic [DATA_W-1:0] rldQ;

  rtmr_ctrl #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .wrLevel    (busWdata[7]),
    .wrRun      (busWdata[3]),
    .wrSel      (busWdata[2:0]),
    .extCountIn (extCountIn),
    .wrapEvent  (wrapEvent),
    .strobes    (strobes),
    .timerLevel (timerOut),
    .runBit     (runBit),
    .clkSel     (clkSel)
  );

  rtmr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (busWdata),
    .cntQ      (cntQ),
    .rldQ      (rldQ),
    .wrapEvent (wrapEvent),
    .irqPulse  (irqPulse),
    .baudTick  (baudTick)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CNT: busRdata = cntQ;
      ADDR_RLD: busRdata = rldQ;
      ADDR_CTL: busRdata = {timerOut, 3'b111, runBit, clkSel};
      default:  busRdata = '0;
    endcase
  end

  AST_FIXED_CTL_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTL) |-> busRdata[6:4] == 3'b111); // R5
endmodule

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       extCountIn = 1'b0;
  logic       timerOut, irqPulse, baudTick;

  int nChecks = 0;
  int nFail   = 0;
  int irqSeen = 0;

  always #5ns clk = ~clk;

  reload_timer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extCountIn(extCountIn),
    .timerOut(timerOut), .irqPulse(irqPulse), .baudTick(baudTick)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  rld;
    logic [15:0] period;
  } vec_t;

  // period = (256 - reload) << sel
  localparam vec_t VECS [8] = '{
    '{sel: 3'd0, rld: 8'hF0, period: 16'd16},
    '{sel: 3'd0, rld: 8'h00, period: 16'd256},
    '{sel: 3'd1, rld: 8'hF8, period: 16'd16},
    '{sel: 3'd2, rld: 8'hFA, period: 16'd24},
    '{sel: 3'd3, rld: 8'hFC, period: 16'd32},
    '{sel: 3'd4, rld: 8'hFE, period: 16'd32},
    '{sel: 3'd5, rld: 8'hFD, period: 16'd96},
    '{sel: 3'd6, rld: 8'hFC, period: 16'd256}
  };

  always @(negedge clk) if (irqPulse) irqSeen++;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1ns;
    d = busRdata;
  endtask

  task automatic waitIrq(input int limit, output bit found);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irqPulse) begin found = 1'b1; break; end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired, no requirement completed: actual hang expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2;
    bit found;
    int n;
    logic lvl;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    busRead(2'd2, rd); check("R6 ctrl reset", rd, 8'h70);
    check("R6 timerOut reset", timerOut, 0);
    check("R6 irq reset", irqPulse, 0);
    check("R6 baud reset", baudTick, 0);
    busRead(2'd3, rd); check("R11 addr3 reads zero", rd, 8'h00);

    // fixed bits and preset level
    busWrite(2'd2, 8'h07);
    busRead(2'd2, rd); check("R5 fixed ones with 0x07", rd, 8'h77);
    busWrite(2'd2, 8'h80);
    busRead(2'd2, rd); check("R5 fixed ones with 0x80", rd, 8'hF0);
    check("R4 preset high level", timerOut, 1);
    busWrite(2'd2, 8'h00);
    check("R4 preset low level", timerOut, 0);

    // counter/reload mirror
    busWrite(2'd0, 8'h37);
    busRead(2'd1, rd); check("R2 counter write mirrors reload", rd, 8'h37);
    busRead(2'd0, rd); check("R11 counter readback", rd, 8'h37);
    busWrite(2'd1, 8'hA5);
    busRead(2'd1, rd); check("R11 reload readback", rd, 8'hA5);
    busRead(2'd0, rd); check("R2 reload write leaves counter", rd, 8'h37);
    repeat (40) @(negedge clk);
    busRead(2'd0, rd); check("R3 stopped counter holds", rd, 8'h37);

    // vector table: prescaled periods, toggle, pulses
    foreach (VECS[i]) begin
      busWrite(2'd2, 8'h00);
      busWrite(2'd0, VECS[i].rld);
      busWrite(2'd2, {5'b00001, VECS[i].sel});
      waitIrq(20000, found);
      check($sformatf("R1 first overflow sel %0d", VECS[i].sel), found, 1);
      check($sformatf("R10 baud with irq sel %0d", VECS[i].sel), baudTick, 1);
      lvl = timerOut;
      n = 0;
      for (int c = 0; c < 20000; c++) begin
        @(negedge clk);
        n++;
        if (irqPulse) break;
      end
      check($sformatf("R7 period sel %0d", VECS[i].sel), n, VECS[i].period);
      check($sformatf("R4 toggle sel %0d", VECS[i].sel), timerOut, !lvl);
      check($sformatf("R10 baud tick sel %0d", VECS[i].sel), baudTick, 1);
      @(negedge clk);
      check($sformatf("R10 irq single cycle sel %0d", VECS[i].sel), irqPulse, 0);
    end

    // halted after running
    busWrite(2'd2, 8'h00);
    busRead(2'd0, rd);
    repeat (30) @(negedge clk);
    busRead(2'd0, rd2); check("R3 run cleared holds count", rd2, rd);

    // external edges
    busWrite(2'd0, 8'hFD);
    busWrite(2'd2, 8'h0F);
    repeat (2) begin
      extCountIn = 1'b1; repeat (4) @(negedge clk);
      extCountIn = 1'b0; repeat (4) @(negedge clk);
    end
    busRead(2'd0, rd); check("R8 two edges count two", rd, 8'hFF);
    irqSeen = 0;
    extCountIn = 1'b1; repeat (4) @(negedge clk);
    extCountIn = 1'b0; repeat (4) @(negedge clk);
    check("R1 external overflow irq count", irqSeen, 1);
    busRead(2'd0, rd); check("R1 external overflow reload", rd, 8'hFD);
    extCountIn = 1'b1; repeat (20) @(negedge clk);
    extCountIn = 1'b0; repeat (4) @(negedge clk);
    busRead(2'd0, rd); check("R8 long level counts once", rd, 8'hFE);

    // software write beats overflow toggle
    busWrite(2'd2, 8'h00);
    busWrite(2'd0, 8'hFE);
    @(negedge clk);
    busWe = 1'b1; busAddr = 2'd2; busWdata = 8'h08;   // run from edge E0
    @(negedge clk);
    busWe = 1'b0;                                     // E1: counter -> FF
    @(negedge clk);
    busWe = 1'b1; busAddr = 2'd2; busWdata = 8'h08;   // E2: overflow + write
    @(negedge clk);
    busWe = 1'b0;
    check("R9 overflow occurred", irqPulse, 1);
    check("R9 written level wins", timerOut, 0);
    @(negedge clk);
    @(negedge clk);
    check("R4 next overflow toggles", timerOut, 1);
    check("R10 next overflow irq", irqPulse, 1);
    busWrite(2'd2, 8'h00);

    summary();
    $finish;
  end
endmodule